// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block drives a serial test bitstream for checking a link end to end. It has two sources. The first is a pseudo-random sequence from a shift register with trinomial feedback x^n + x^y + 1, where n and y are set at run time. The second is a user word of 1 to 32 bits that is sent over and over. Whichever source is selected, single-bit errors can be forced into the stream. A request can come from a software command, from a change of level on an external pin, or from a rate divider that hits once every 10^k bits.

Configuration is presented on plain input fields and captured by a load strobe. The strobe only acts while the block enable is high. A downstream framer asks for one bit per cycle on `bit_en`. The block answers one cycle later on `tx_data`, qualified by `tx_valid`.

Top module: `testpat_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `tx_valid` and `tx_data` are 0 until the first enabled bit request.
- R2: A bit is produced only in a cycle where `cfg_enable` and `bit_en` are high and `cfg_load` is not acting. It appears on `tx_data` with `tx_valid`=1 one clock later. In every other cycle `tx_valid` and `tx_data` are 0, and the generator state is held.
- R3: With `cfg_mode`=0 (pseudo-random), the state s holds n bits. Each bit sent is s[n-1]. The feedback s[n-1] xor s[y-1] is then shifted in at bit 0. Both n (1 to 32) and y (1 to n-1) are taken at load. A tap outside 1..n-1 drops the tap term, so the register only rotates.
- R4: A seed that is zero after masking to n bits is replaced by n ones, so the register never sits at all-zero.
- R5: With `cfg_mode`=1 (repeat), the loaded word is sent from bit 0 upward, through bit L-1, and then wraps to bit 0. L is `cfg_len`. A length of 0 or above 32 acts as 32.
- R6: A load takes effect only while `cfg_enable` is high. A strobe while the block is disabled leaves the sequence untouched. The load cycle itself produces no bit.
- R7: A high `err_single` in an enabled cycle inverts exactly one later bit, the next one produced, and the request then clears. Requests while disabled are dropped.
- R8: Either edge on `err_pin` is synchronized through two flops and then requests one inverted bit, in the same way as R7.
- R9: With `err_rate_en` high, every 10^k-th bit after the load is inverted, counting bits since the load. k is `err_rate_k`; 0 acts as 1 and values above 7 act as 7.
- R10: When a pending request and a rate hit fall on the same bit, that bit is inverted once and the pending request is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cfg_mode | input | 1 | 0 pseudo-random, 1 repeating word |
| cfg_len | input | 6 | Register length n or word length L |
| cfg_tap | input | 6 | Feedback tap y |
| cfg_seed | input | 32 | Seed or repeating word |
| cfg_load | input | 1 | Load strobe |
| err_single | input | 1 | Single-error command |
| err_pin | input | 1 | External error trigger (asynchronous) |
| err_rate_en | input | 1 | Enable rate-based errors |
| err_rate_k | input | 3 | Rate exponent k |
| bit_en | input | 1 | Bit request |
| tx_data | output | 1 | Serial output bit |
| tx_valid | output | 1 | Output bit qualifier |

## Verification
Several properties are checked on every cycle. The output stays quiet after the enable drops. The shift register never holds zero. The repeat index stays inside the loaded length. A pending error clears once it has been used. The rate counter restarts after each hit. The actual bit sequences are shown only by the bench scenarios: each polynomial length with several taps, every repeat length, the clamped lengths and rates, the ignored load, and each error trigger alone or coinciding with a rate hit. These are compared against a model built from the requirement text.

// File: rtl/tpg_pkg.sv
// Package: shared types of the test pattern generator.
// Assumes: nothing beyond the 1-bit mode encoding listed in the brief.
package tpg_pkg;
    typedef enum logic {
        MODE_PRBS = 1'b0,
        MODE_REP  = 1'b1
    } tpg_mode_e;
endpackage

// File: rtl/tpg_prbs.sv
// Module: tpg_prbs
// Run-time programmable trinomial shift register. Length and tap are captured at
// load; each step emits the top bit and shifts in top xor tap.
// Assumes: WORD_W >= 2; load and step are never high together.
module tpg_prbs #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [LEN_W-1:0]  tap_in,
    input  logic [WORD_W-1:0] seed_in,
    output logic              bit_out
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_W);

    logic [WORD_W-1:0] state_q;
    logic [LEN_W-1:0]  n_q;
    logic [LEN_W-1:0]  y_q;
    logic [LEN_W-1:0]  len_eff;
    logic [WORD_W-1:0] mask_in;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] seeded;
    logic [WORD_W-1:0] load_val;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] next_val;
    logic              top_bit;
    logic              tap_bit;

    // Clamp the requested length into 1..WORD_W.
    always_comb begin
        len_eff = ((len_in == '0) || (len_in > FULL_LEN)) ? FULL_LEN : len_in;
    end

    // Length masks for the incoming and the active configuration.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign mask_in[i] = (LEN_W'(i) < len_eff);
        assign mask_q[i]  = (LEN_W'(i) < n_q);
    end

    // Select the top bit and the tap bit of the active length.
    always_comb begin
        top_bit = 1'b0;
        tap_bit = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (LEN_W'(i) == n_q - LEN_W'(1)) top_bit = state_q[i];
            if ((y_q != '0) && (y_q < n_q) && (LEN_W'(i) == y_q - LEN_W'(1))) tap_bit = state_q[i];
        end
    end

    // Next state and load value, with the all-zero guard.
    always_comb begin
        shifted  = {state_q[WORD_W-2:0], top_bit ^ tap_bit} & mask_q;
        next_val = (shifted == '0) ? mask_q : shifted;
        seeded   = seed_in & mask_in;
        load_val = (seeded == '0) ? mask_in : seeded;
    end

    // State and captured configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
            n_q     <= FULL_LEN;
            y_q     <= '0;
        end else if (load) begin
            state_q <= load_val;
            n_q     <= len_eff;
            y_q     <= tap_in;
        end else if (step) begin
            state_q <= next_val;
        end
    end

    assign bit_out = top_bit;

    // R4: the register never holds the lock-up value.
    a_r4_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/tpg_rep.sv
// Module: tpg_rep
// Repeating word source. Word and length are captured at load; bits go out
// LSB first and the index wraps after the last bit.
// Assumes: load and step are never high together.
module tpg_rep #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [WORD_W-1:0] pat_in,
    output logic              bit_out
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_W);

    logic [WORD_W-1:0] pat_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_eff;

    // Clamp the requested length into 1..WORD_W.
    always_comb begin
        len_eff = ((len_in == '0) || (len_in > FULL_LEN)) ? FULL_LEN : len_in;
    end

    // Pick the current bit of the stored word.
    always_comb begin
        bit_out = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (LEN_W'(i) == idx_q) bit_out = pat_q[i];
        end
    end

    // Word, length and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            len_q <= FULL_LEN;
            idx_q <= '0;
        end else if (load) begin
            pat_q <= pat_in;
            len_q <= len_eff;
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q >= len_q - LEN_W'(1)) ? '0 : idx_q + LEN_W'(1);
        end
    end

    // R5: the index stays inside the loaded length.
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < len_q);
endmodule

// File: rtl/tpg_errins.sv
// Module: tpg_errins
// Error request logic: a command, a synchronized pin edge, and a 1-in-10^k
// counter over produced bits. Produces a one-bit inversion flag per step.
// Assumes: err_pin is asynchronous; the other inputs are synchronous.
module tpg_errins #(
    parameter int K_MAX = 7,
    parameter int K_W   = $clog2(K_MAX + 1),
    parameter int CNT_W = $clog2(10 ** K_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           load,
    input  logic           step,
    input  logic           single_req,
    input  logic           pin,
    input  logic           rate_en,
    input  logic [K_W-1:0] rate_k,
    output logic           inject
);
    logic             sync1_q, sync2_q, sync3_q;
    logic             pin_edge;
    logic             pending_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic             rate_hit;

    // 10^k with k clamped into 1..K_MAX.
    function automatic logic [CNT_W-1:0] decade(input logic [K_W-1:0] k);
        logic [CNT_W-1:0] p;
        int kk;
        kk = int'(k);
        if (kk < 1) kk = 1;
        if (kk > K_MAX) kk = K_MAX;
        p = CNT_W'(1);
        for (int i = 0; i < K_MAX; i++) begin
            if (i < kk) p = p * CNT_W'(10);
        end
        return p;
    endfunction

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            sync3_q <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    // Rate period and the current hit condition.
    always_comb begin
        pin_edge = sync2_q ^ sync3_q;
        period   = decade(rate_k);
        rate_hit = rate_en && (cnt_q >= period - CNT_W'(1));
        inject   = step && (pending_q || rate_hit);
    end

    // Pending flag: set by a request, consumed by the next produced bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pending_q <= 1'b0;
        end else if (single_req || pin_edge) begin
            pending_q <= 1'b1;
        end else if (step) begin
            pending_q <= 1'b0;
        end
    end

    // Decimal divider over produced bits, restarted at load or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !rate_en || load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= rate_hit ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R7: a request that is used and not renewed clears.
    a_r7_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && step && !single_req && !pin_edge) |=> !pending_q);

    // R9: the divider restarts after each rate hit.
    a_r9_cnt_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_hit && step && enable && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/testpat_gen.sv
// Module: testpat_gen (top)
// Selects the pseudo-random or repeating source, applies error inversion and
// registers one output bit per enabled request.
// Assumes: configuration fields are stable in the load cycle.
module testpat_gen #(
    parameter int WORD_W = 32,
    parameter int K_MAX  = 7,
    localparam int LEN_W = $clog2(WORD_W + 1),
    localparam int K_W   = $clog2(K_MAX + 1),
    localparam int CNT_W = $clog2(10 ** K_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LEN_W-1:0]  cfg_tap,
    input  logic [WORD_W-1:0] cfg_seed,
    input  logic              cfg_load,
    input  logic              err_single,
    input  logic              err_pin,
    input  logic              err_rate_en,
    input  logic [K_W-1:0]    err_rate_k,
    input  logic              bit_en,
    output logic              tx_data,
    output logic              tx_valid
);
    import tpg_pkg::*;

    tpg_mode_e mode;
    logic      load_eff;
    logic      step;
    logic      prbs_bit;
    logic      rep_bit;
    logic      gen_bit;
    logic      inject;
    logic      data_q;
    logic      valid_q;

    // Decode the control strobes for this cycle.
    always_comb begin
        mode     = tpg_mode_e'(cfg_mode);
        load_eff = cfg_load && cfg_enable;
        step     = cfg_enable && bit_en && !load_eff;
        gen_bit  = (mode == MODE_REP) ? rep_bit : prbs_bit;
    end

    tpg_prbs #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_eff && (mode == MODE_PRBS)),
        .step    (step && (mode == MODE_PRBS)),
        .len_in  (cfg_len),
        .tap_in  (cfg_tap),
        .seed_in (cfg_seed),
        .bit_out (prbs_bit)
    );

    tpg_rep #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_eff && (mode == MODE_REP)),
        .step    (step && (mode == MODE_REP)),
        .len_in  (cfg_len),
        .pat_in  (cfg_seed),
        .bit_out (rep_bit)
    );

    tpg_errins #(.K_MAX(K_MAX), .K_W(K_W), .CNT_W(CNT_W)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .load       (load_eff),
        .step       (step),
        .single_req (err_single),
        .pin        (err_pin),
        .rate_en    (err_rate_en),
        .rate_k     (err_rate_k),
        .inject     (inject)
    );

    // Output register: one bit per step, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= step ? (gen_bit ^ inject) : 1'b0;
            valid_q <= step;
        end
    end

    assign tx_data  = data_q;
    assign tx_valid = valid_q;

    // R2: a disabled block produces no bit in the next cycle.
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !tx_valid);

    // R6: a load cycle produces no bit.
    a_r6_load_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_enable) |=> !tx_valid);
endmodule

// File: tb/testpat_gen_bench.sv
`timescale 1ns/1ps
module testpat_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_mode = 1'b0, cfg_load = 1'b0;
    logic [5:0]  cfg_len = 6'd0, cfg_tap = 6'd0;
    logic [31:0] cfg_seed = 32'd0;
    logic        err_single = 1'b0, err_pin = 1'b0, err_rate_en = 1'b0;
    logic [2:0]  err_rate_k = 3'd0;
    logic        bit_en = 1'b0;
    logic        tx_data, tx_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_mode;
    logic [31:0] m_s, m_p;
    int          m_n, m_y, m_L, m_i;

    always #2.5 clk = ~clk;

    testpat_gen u_testpat_gen (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_seed(cfg_seed), .cfg_load(cfg_load),
        .err_single(err_single), .err_pin(err_pin), .err_rate_en(err_rate_en),
        .err_rate_k(err_rate_k), .bit_en(bit_en), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    function automatic logic [31:0] len_mask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic int clamp_len(int n);
        return (n == 0 || n > 32) ? 32 : n;
    endfunction

    // Next expected bit per R3/R5, advancing the model.
    function automatic logic model_bit();
        logic b, t;
        if (m_mode == 1'b0) begin
            b = m_s[m_n-1];
            t = (m_y >= 1 && m_y < m_n) ? m_s[m_y-1] : 1'b0;
            m_s = ((m_s << 1) | {31'd0, b ^ t}) & len_mask(m_n);
            if (m_s == 32'd0) m_s = len_mask(m_n);
        end else begin
            b = m_p[m_i];
            m_i = (m_i == m_L - 1) ? 0 : m_i + 1;
        end
        return b;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(logic mode, int len, int tap, logic [31:0] val);
        cfg_mode = mode; cfg_len = 6'(len); cfg_tap = 6'(tap); cfg_seed = val;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        check("R6 load cycle no bit", {31'd0, tx_valid}, 32'd0);
        m_mode = mode;
        if (mode == 1'b0) begin
            m_n = clamp_len(len); m_y = tap;
            m_s = val & len_mask(m_n);
            if (m_s == 32'd0) m_s = len_mask(m_n);
        end else begin
            m_p = val; m_L = clamp_len(len); m_i = 0;
        end
    endtask

    task automatic step_bit(string tag, logic inv);
        logic e;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        e = model_bit() ^ inv;
        check({tag, " valid"}, {31'd0, tx_valid}, 32'd1);
        check({tag, " data"}, {31'd0, tx_data}, {31'd0, e});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 idle quiet", {30'd0, tx_valid, tx_data}, 32'd0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int ones;
        repeat (3) @(negedge clk);
        check("R1 reset quiet", {30'd0, tx_valid, tx_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset quiet", {30'd0, tx_valid, tx_data}, 32'd0);
        cfg_enable = 1'b1;

        // R3: every length, several taps.
        for (int n = 1; n <= 32; n++) begin
            for (int t = 0; t < 3; t++) begin
                int y;
                y = (t == 0) ? 1 : (t == 1) ? n - 1 : n / 2;
                do_load(1'b0, n, y, 32'h9E37_79B9 ^ (32'(n) << 3));
                for (int b = 0; b < 24; b++) step_bit("R3 prbs sweep", 1'b0);
            end
        end
        // R3: maximal sequences have 2^(n-1) ones per period.
        do_load(1'b0, 7, 6, 32'd1);
        ones = 0;
        for (int b = 0; b < 127; b++) begin
            bit_en = 1'b1; @(negedge clk); ones += int'(tx_data);
        end
        bit_en = 1'b0;
        check("R3 n7 ones per period", 32'(ones), 32'd64);
        do_load(1'b0, 3, 2, 32'd5);
        ones = 0;
        for (int b = 0; b < 7; b++) begin
            bit_en = 1'b1; @(negedge clk); ones += int'(tx_data);
        end
        bit_en = 1'b0;
        check("R3 n3 ones per period", 32'(ones), 32'd4);
        // R3: out-of-range taps rotate.
        do_load(1'b0, 8, 0, 32'h0000_00B1);
        for (int b = 0; b < 20; b++) step_bit("R3 tap zero rotate", 1'b0);
        do_load(1'b0, 8, 8, 32'h0000_0013);
        for (int b = 0; b < 20; b++) step_bit("R3 tap n rotate", 1'b0);
        // R4: zero seed replaced by ones.
        do_load(1'b0, 5, 3, 32'hFFFF_FFE0);
        for (int b = 0; b < 5; b++) step_bit("R4 zero seed ones", 1'b0);
        for (int b = 0; b < 30; b++) step_bit("R4 zero seed run", 1'b0);

        // R5: every repeat length, plus clamped lengths.
        for (int L = 1; L <= 32; L++) begin
            do_load(1'b1, L, 0, 32'hA5C3_96E1 ^ (32'(L) * 32'h0101_0101));
            for (int b = 0; b < 2 * L + 3; b++) step_bit("R5 repeat sweep", 1'b0);
        end
        do_load(1'b1, 0, 0, 32'h8000_0001);
        for (int b = 0; b < 40; b++) step_bit("R5 len0 as 32", 1'b0);
        do_load(1'b1, 40, 0, 32'h0F0F_1234);
        for (int b = 0; b < 40; b++) step_bit("R5 len40 as 32", 1'b0);

        // R2: gaps in bit requests hold the sequence.
        do_load(1'b0, 11, 2, 32'h5A5);
        for (int b = 0; b < 5; b++) step_bit("R2 before gap", 1'b0);
        idle(3);
        for (int b = 0; b < 5; b++) step_bit("R2 after gap", 1'b0);

        // R6: load while disabled is ignored; disabled holds state.
        cfg_enable = 1'b0;
        bit_en = 1'b1;
        @(negedge clk);
        check("R2 disabled no bit", {31'd0, tx_valid}, 32'd0);
        bit_en = 1'b0;
        cfg_mode = 1'b0; cfg_len = 6'd4; cfg_tap = 6'd1; cfg_seed = 32'h3;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        idle(2);
        cfg_enable = 1'b1;
        for (int b = 0; b < 12; b++) step_bit("R6 ignored load continues", 1'b0);

        // R7: single command inverts one bit.
        do_load(1'b1, 9, 0, 32'h0000_016D);
        step_bit("R7 before", 1'b0);
        err_single = 1'b1; @(negedge clk); err_single = 1'b0;
        step_bit("R7 inverted bit", 1'b1);
        step_bit("R7 next clean", 1'b0);
        step_bit("R7 next clean", 1'b0);
        // R7: command while disabled is dropped.
        cfg_enable = 1'b0;
        err_single = 1'b1; @(negedge clk); err_single = 1'b0;
        cfg_enable = 1'b1;
        step_bit("R7 disabled request dropped", 1'b0);

        // R8: each pin edge inverts one bit.
        err_pin = 1'b1; idle(4);
        step_bit("R8 rising edge", 1'b1);
        step_bit("R8 after rising", 1'b0);
        err_pin = 1'b0; idle(4);
        step_bit("R8 falling edge", 1'b1);
        step_bit("R8 after falling", 1'b0);

        // R9: rate 1 in 10, 1 in 100, k=0 acts as 1.
        err_rate_en = 1'b1;
        err_rate_k = 3'd1;
        do_load(1'b0, 13, 4, 32'h1ACE);
        for (int b = 1; b <= 35; b++) step_bit("R9 rate k1", (b % 10) == 0);
        err_rate_k = 3'd2;
        do_load(1'b1, 23, 0, 32'h0055_AA33);
        for (int b = 1; b <= 205; b++) step_bit("R9 rate k2", (b % 100) == 0);
        err_rate_k = 3'd0;
        do_load(1'b0, 9, 5, 32'h1F1);
        for (int b = 1; b <= 25; b++) step_bit("R9 rate k0 as k1", (b % 10) == 0);

        // R10: pending request and rate hit on the same bit.
        err_rate_k = 3'd1;
        do_load(1'b1, 17, 0, 32'h0001_2C3D);
        for (int b = 1; b <= 9; b++) step_bit("R10 lead-in", 1'b0);
        err_single = 1'b1; @(negedge clk); err_single = 1'b0;
        step_bit("R10 single inversion", 1'b1);
        step_bit("R10 pending consumed", 1'b0);
        err_rate_en = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule